// File: doc/BRIEF.md
# Multi-Device SPI Chip-Select Controller

This block drives the chip-select lines of an SPI master that can address several devices on one bus. It takes a device index, a mode choice between automatic and manual control, a manual level and a global polarity control, and it takes the start and busy indications of the transfer engine. From these it produces one registered chip-select line per device.

A single polarity input decides both the asserted level of the addressed line and the resting level of every other line. Idle devices therefore stay deselected under either polarity. In automatic mode the addressed line is asserted while the engine is starting or running a burst. In manual mode software holds the addressed line at the written level, whatever the engine is doing. The device index is captured so that a change made in the middle of a burst cannot move the select to another device.

Top module: `spi_cs_ctrl`

## Requirements
- R1: While reset is held low, and in the first cycle after it, every chip-select line is high. This is the inactive level for an active-low polarity, which is the polarity assumed out of reset.
- R2: One clock after any input pattern, every line other than the addressed one sits at the level of `act_low`: 1 when it is set, 0 when it is clear.
- R3: In automatic mode (`manual_en` = 0) with `xfer_start` and `xfer_busy` both low, the addressed line also sits at its inactive level, which equals `act_low`, one clock later.
- R4: In automatic mode, when `xfer_start` or `xfer_busy` is high, the addressed line goes to its active level (`~act_low`) one clock later. It stays there until the clock after `xfer_busy` falls.
- R5: In manual mode (`manual_en` = 1) the addressed line follows `manual_lvl` one clock later, whatever the state of `xfer_start` and `xfer_busy`.
- R6: The addressed line is chosen by `dev_sel` (value i selects `cs_line[i]`). A value presented while `xfer_busy` is high is ignored: the index captured in the last cycle with `xfer_busy` low stays in use until `xfer_busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 2 | Index of the device to address |
| manual_en | input | 1 | 1 = manual control of the addressed line |
| manual_lvl | input | 1 | Level driven on the addressed line in manual mode |
| act_low | input | 1 | 1 = lines are active low and idle high |
| xfer_start | input | 1 | Transfer engine starts a burst this cycle |
| xfer_busy | input | 1 | Transfer engine is shifting a burst |
| cs_line | output | 4 | Chip-select lines, one per device |

## Verification
The hardest case to reach is a change of `dev_sel` in the middle of a burst, followed by the release of the burst. The bench has to show that the old line stays asserted and the new one stays idle while `xfer_busy` is high. It then has to show that the new index is taken up in the cycle `xfer_busy` falls. A directed sequence raises start and busy on one device, moves the index twice during the burst under both polarities, and then drops busy while manual mode exposes the newly captured index. Random cycles drawn from a fixed seed add start/busy overlaps and polarity flips during bursts, and a bench model of the index capture checks every cycle.

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  dev_sel,
  input  logic              manual_en,
  input  logic              manual_lvl,
  input  logic              act_low,
  input  logic              xfer_start,
  input  logic              xfer_busy,
  output logic [NUM_CS-1:0] cs_line
);

  logic [IDX_W-1:0]  dev_q;
  logic [IDX_W-1:0]  dev_eff;
  logic              engaged;
  logic              sel_lvl;
  logic [NUM_CS-1:0] cs_nxt;

  assign dev_eff = xfer_busy ? dev_q : dev_sel;
  assign engaged = xfer_start | xfer_busy;
  assign sel_lvl = manual_en ? manual_lvl : (act_low ^ engaged);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_nxt[i] = (dev_eff == IDX_W'(i)) ? sel_lvl : act_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q   <= '0;
      cs_line <= '1;
    end else begin
      dev_q   <= dev_eff;
      cs_line <= cs_nxt;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> cs_line == '1);

  // R2
  others_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(cs_line ^ {NUM_CS{$past(act_low)}}) <= 1);

  // R3
  auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_en && !engaged) |=> cs_line == {NUM_CS{$past(act_low)}});

  // R4
  auto_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_en && engaged) |=> cs_line[$past(dev_eff)] == !$past(act_low));

  // R5
  manual_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    manual_en |=> cs_line[$past(dev_eff)] == $past(manual_lvl));

  // R6
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> $stable(dev_q));

endmodule

// File: tb/spi_cs_ctrl_test.sv
module spi_cs_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] dev_sel = 0;
  logic manual_en = 0, manual_lvl = 0, act_low = 1, xfer_start = 0, xfer_busy = 0;
  logic [3:0] cs_line;
  int n_chk = 0, n_fail = 0;
  logic [1:0] mdev = 0;

  always #10 clk = ~clk;

  spi_cs_ctrl uut (.clk, .rst_n, .dev_sel, .manual_en, .manual_lvl,
                   .act_low, .xfer_start, .xfer_busy, .cs_line);

  function automatic logic [3:0] model(logic [1:0] d, logic man, logic lvl,
                                       logic al, logic eng);
    logic [3:0] r = {4{al}};
    r[d] = man ? lvl : (al ^ eng);
    return r;
  endfunction

  function automatic string tag_of(logic man, logic eng);
    if (man) return "R5";
    return eng ? "R4" : "R3";
  endfunction

  task automatic check(logic [3:0] exp, string tag);
    n_chk++;
    if (cs_line !== exp) begin
      n_fail++;
      $display("FAIL %s: cs_line=%b expected %b", tag, cs_line, exp);
    end
  endtask

  task automatic cyc(logic [1:0] d, logic man, logic lvl, logic al,
                     logic st, logic bz, string tag);
    logic [1:0] eff;
    logic [3:0] exp;
    dev_sel = d; manual_en = man; manual_lvl = lvl; act_low = al;
    xfer_start = st; xfer_busy = bz;
    eff = bz ? mdev : d;
    mdev = eff;
    exp = model(eff, man, lvl, al, st | bz);
    @(posedge clk);
    @(negedge clk);
    if (tag == "") begin
      // R2 non-selected lines rest at act_low
      n_chk++;
      for (int i = 0; i < 4; i++)
        if (i != eff && cs_line[i] !== al) begin
          n_fail++;
          $display("FAIL R2: line %0d=%b expected %b", i, cs_line[i], al);
          break;
        end
      check(exp, tag_of(man, st | bz));
    end else check(exp, tag);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(4'hF, "R1");
    rst_n = 1;
    @(negedge clk);
    check(4'hF, "R1");

    cyc(2, 0, 0, 1, 0, 0, "R3");
    cyc(2, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 1, 0, "R4");
    cyc(1, 0, 0, 1, 0, 1, "R4");
    cyc(3, 0, 0, 1, 0, 1, "R6");
    cyc(0, 0, 0, 1, 0, 1, "R6");
    cyc(0, 0, 0, 0, 0, 1, "R6");
    cyc(3, 1, 0, 1, 0, 0, "R6");
    cyc(3, 1, 1, 0, 0, 0, "R5");
    cyc(3, 1, 1, 0, 1, 0, "R5");
    cyc(2, 1, 0, 1, 0, 1, "R5");
    cyc(1, 0, 0, 0, 0, 0, "R2");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] r = $urandom;
      cyc(r[1:0], r[2] & r[3], r[4], r[5] | r[6], r[7] & r[8], r[9] | r[10], "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule